// File: doc/BRIEF.md
# Pin Multiplexer with Qualified Inputs

This block sits between a bank of chip pads and the logic inside the chip. Each pin is set on its own either to general-purpose use or to a peripheral. In general-purpose mode, an output-data register and a direction register drive the pad. In peripheral mode, the peripheral's own output and output-enable drive it.

Every pad input passes through a two-flop synchroniser and then a qualification filter. The filter accepts a new level only after that level has held for a programmed number of consecutive sample ticks. A prescaler sets the spacing of those ticks. The filtered value feeds the general-purpose read path and the peripheral input at the same time, whatever the mode.

Software sets up the block through a simple write port: one strobe, an address and a data word. Three of the addresses set, clear or toggle bits of the output-data register, so no read-modify-write is needed.

Top module: `gpio_pin_mux`

## Requirements
- R1: When a bit of the mode register (address 0) is 1, that pin's `pad_out` and `pad_oe` equal `per_out` and `per_oe`. When the bit is 0, they equal the output-data bit and the direction bit.
- R2: After reset, the mode, direction, output-data, prescaler and qualification registers are all zero. Every pin is therefore an input (`pad_oe` = 0) in general-purpose mode.
- R3: A write to address 1 loads the direction register (1 = output). A write to address 2 loads the output-data register. Each change is visible at the pads on the next cycle.
- R4: A write to address 3 sets, address 4 clears and address 5 toggles the output-data bits that are 1 in the write data. All other bits keep their values.
- R5: With a qualification length of 0 (address 7, bits 3:0), the filtered input follows the pad three clock edges after the pad changes.
- R6: With a qualification length N from 1 to 15, the filtered value takes a new level only after N consecutive sample ticks at that level. A return to the old level before then restarts the count.
- R7: The prescaler (address 6, bits 7:0) holding P gives one sample tick every P+1 core clocks.
- R8: The filtered value appears on both `gpio_rd` and `per_in` in both modes.
- R9: A pin set as an output reads back its qualified pad level on `gpio_rd`, not the contents of the output-data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| per_out | input | NPINS | Peripheral output levels |
| per_oe | input | NPINS | Peripheral output enables |
| per_in | output | NPINS | Filtered inputs to the peripherals |
| gpio_rd | output | NPINS | Filtered inputs for the general-purpose read path |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad output enables |

## Verification
A wrong register value or a wrong mode bit shows up on `pad_out` or `pad_oe` in the cycle after the write that caused it. A stale prescaler count or qualification count shows up later: the filtered outputs move one tick early or late, which can be up to (P+1)·N cycles after the pad edge. The bench therefore runs a behavioural model next to the design and compares all four outputs on every clock, so any such drift is reported in the cycle it first appears.

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int NPINS = 8,
  parameter int QW    = 4,
  parameter int PSW   = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [NPINS-1:0] per_out,
  input  logic [NPINS-1:0] per_oe,
  output logic [NPINS-1:0] per_in,
  output logic [NPINS-1:0] gpio_rd,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  localparam logic [2:0] A_MODE = 3'd0, A_DIR = 3'd1, A_DATA = 3'd2, A_SET = 3'd3,
                         A_CLR = 3'd4, A_TGL = 3'd5, A_PSC = 3'd6, A_QUAL = 3'd7;

  logic [NPINS-1:0] mode_r, dir_r, dout_r;
  logic [PSW-1:0]   psc_r, div_r;
  logic [QW-1:0]    qlen_r;
  logic [NPINS-1:0] sync1, sync2, filt;
  logic             tick;
  wire  [NPINS-1:0] wmask = wr_data[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r <= '0; dir_r <= '0; dout_r <= '0; psc_r <= '0; qlen_r <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE: mode_r <= wmask;
        A_DIR:  dir_r  <= wmask;
        A_DATA: dout_r <= wmask;
        A_SET:  dout_r <= dout_r | wmask;
        A_CLR:  dout_r <= dout_r & ~wmask;
        A_TGL:  dout_r <= dout_r ^ wmask;
        A_PSC:  psc_r  <= wr_data[PSW-1:0];
        A_QUAL: qlen_r <= wr_data[QW-1:0];
        default: ;
      endcase
    end
  end

  assign tick = (div_r >= psc_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_r <= '0;
    else        div_r <= tick ? '0 : div_r + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0; sync2 <= '0;
    end else begin
      sync1 <= pad_in; sync2 <= sync1;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [QW-1:0] run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run <= '0; filt[i] <= 1'b0;
      end else if (qlen_r == '0) begin
        run <= '0; filt[i] <= sync2[i];
      end else if (tick) begin
        if (sync2[i] == filt[i]) run <= '0;
        else if ({1'b0, run} + 1'b1 >= {1'b0, qlen_r}) begin
          run <= '0; filt[i] <= sync2[i];
        end else run <= run + 1'b1;
      end
    end

    assert_hold_when_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sync2[i] == filt[i]) |=> $stable(filt[i]));
    assert_move_only_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (qlen_r != '0 && !tick) |=> $stable(filt[i]));
  end

  assign pad_out = (mode_r & per_out) | (~mode_r & dout_r);
  assign pad_oe  = (mode_r & per_oe)  | (~mode_r & dir_r);
  assign gpio_rd = filt;
  assign per_in  = filt;

  assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_SET) |=> ((dout_r & $past(wmask)) == $past(wmask)));
  assert_clear_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CLR) |=> ((dout_r & $past(wmask)) == '0));
  assert_toggle_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_TGL) |=> (dout_r == ($past(dout_r) ^ $past(wmask))));
  assert_pass_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (qlen_r == '0) |=> (filt == $past(sync2)));
endmodule

// File: tb/tb_gpio_pin_mux.sv
module tb_gpio_pin_mux;
  localparam int N = 8;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [N-1:0] per_out = 0, per_oe = 0, pad_in = 0;
  logic [N-1:0] per_in, gpio_rd, pad_out, pad_oe;
  int checks = 0, failures = 0;
  string tag = "R2";

  gpio_pin_mux #(.NPINS(N)) dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .per_out(per_out), .per_oe(per_oe), .per_in(per_in), .gpio_rd(gpio_rd),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

  always #5 clk = ~clk;

  // behavioural reference
  logic [N-1:0] m_mode, m_dir, m_dout, m_s1, m_s2, m_f;
  int m_psc, m_div, m_q;
  int m_run [N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_dir = 0; m_dout = 0; m_s1 = 0; m_s2 = 0; m_f = 0;
      m_psc = 0; m_div = 0; m_q = 0;
      for (int i = 0; i < N; i++) m_run[i] = 0;
    end else begin
      bit tk;
      tk = (m_div >= m_psc);
      for (int i = 0; i < N; i++) begin
        if (m_q == 0) begin m_f[i] = m_s2[i]; m_run[i] = 0; end
        else if (tk) begin
          if (m_s2[i] == m_f[i]) m_run[i] = 0;
          else if (m_run[i] + 1 >= m_q) begin m_f[i] = m_s2[i]; m_run[i] = 0; end
          else m_run[i]++;
        end
      end
      m_div = tk ? 0 : m_div + 1;
      m_s2 = m_s1; m_s1 = pad_in;
      if (wr_en) case (wr_addr)
        0: m_mode = wr_data[N-1:0];
        1: m_dir = wr_data[N-1:0];
        2: m_dout = wr_data[N-1:0];
        3: m_dout |= wr_data[N-1:0];
        4: m_dout &= ~wr_data[N-1:0];
        5: m_dout ^= wr_data[N-1:0];
        6: m_psc = wr_data[7:0];
        7: m_q = wr_data[3:0];
        default: ;
      endcase
    end
  end

  task automatic chk(string name, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("pad_out", pad_out, (m_mode & per_out) | (~m_mode & m_dout));
    chk("pad_oe", pad_oe, (m_mode & per_oe) | (~m_mode & m_dir));
    chk("gpio_rd", gpio_rd, m_f);
    chk("per_in", per_in, m_f);
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1;
    #1; tag = "R2";
    chk("reset oe", pad_oe, '0); chk("reset out", pad_out, '0);
    idle(2);
    tag = "R3"; wr(1, 32'hFF); wr(2, 32'hA5);
    #1 chk("dir", pad_oe, 8'hFF); chk("data", pad_out, 8'hA5);
    tag = "R4"; wr(3, 32'h0A); #1 chk("set", pad_out, 8'hAF);
    wr(4, 32'h21); #1 chk("clear", pad_out, 8'h8E);
    wr(5, 32'hF0); #1 chk("toggle", pad_out, 8'h7E);
    tag = "R9"; pad_in = 8'h81; idle(4);
    chk("read output pin", gpio_rd, 8'h81);
    tag = "R1"; per_out = 8'h3C; per_oe = 8'h55; wr(0, 32'h0F);
    #1 chk("mode out", pad_out, 8'h7C); chk("mode oe", pad_oe, 8'hF5);
    per_out = 8'hC3; per_oe = 8'hAA; idle(2);
    tag = "R5"; pad_in = 8'h5A; idle(1);
    chk("pass early", gpio_rd, 8'h81);
    idle(2); chk("pass three edges", per_in, 8'h5A);
    tag = "R6"; wr(6, 32'd2); wr(7, 32'd3);
    pad_in = 8'hA5; idle(3); chk("not yet qualified", gpio_rd, 8'h5A);
    idle(12); chk("qualified", gpio_rd, 8'hA5);
    pad_in = 8'h00; idle(4); pad_in = 8'hA5; idle(20);
    chk("glitch rejected", gpio_rd, 8'hA5);
    tag = "R7"; wr(6, 32'd0); wr(7, 32'd15);
    pad_in = 8'h0F; idle(10); chk("under length", gpio_rd, 8'hA5);
    idle(12); chk("full length", gpio_rd, 8'h0F);
    tag = "R8"; wr(0, 32'h00); wr(7, 32'd1); pad_in = 8'hF0; idle(6);
    chk("gpio path", gpio_rd, 8'hF0); chk("periph path", per_in, 8'hF0);
    wr(6, 32'd5); wr(7, 32'd4);
    for (int k = 0; k < 40; k++) begin pad_in = 8'(k * 37); idle(k % 9 + 1); end
    idle(60);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule